// File: doc/BRIEF.md
# Chained Descriptor DMA Transfer Sequencer

This block copies 32-bit DWORDs from one memory-style port to another through a 16-entry staging FIFO. A transfer is described by a descriptor of four DWORDs: a source address, a destination address, a DWORD count and the address of the next descriptor. A start pulse hands the block the address of the first descriptor. The block fetches that descriptor over a separate read-only port and then moves the data. It alternates read phases on the source port with write phases on the destination port, and the two never overlap. A direction input, latched at start, picks port A or port B as the source. The other port is the destination.

The two-bit mode input is latched at start. Mode `00` moves one DWORD per phase. Mode `01` moves sixteen DWORDs per phase. In that mode the last phase of a descriptor is shortened when the count is not a multiple of sixteen. Mode values `1x` are reserved: the block raises an error flag and does nothing else.

At the end of each descriptor the block samples the link-halt input. When that input is 0, the block loads the descriptor's link field as the new descriptor address and fetches again. When it is 1, the block pulses `done` and sets a sticky `done_flag`.

The states are IDLE, FETCH, PLAN, RD, WR, LINK, FINISH and FAULT. The transitions are:
- IDLE→FETCH on a start with a valid mode.
- IDLE→FAULT on a start with a reserved mode.
- FETCH→PLAN after the fourth descriptor word.
- PLAN→WR when the FIFO holds enough for a write phase.
- PLAN→RD when there is room for a read phase.
- PLAN→LINK when the count is exhausted.
- RD→PLAN and WR→PLAN after the last beat of the phase.
- LINK→FETCH when link-halt is 0.
- LINK→FINISH when link-halt is 1.
- FINISH→IDLE and FAULT→IDLE unconditionally.

Top module: `dwd_chain_dma`

## Requirements
- R1: In mode 00, every read phase moves exactly one DWORD from the source port, and it is followed at once by a write phase of one DWORD to the destination port.
- R2: In mode 01, a read phase of up to 16 DWORDs starts only when at least 16 FIFO entries are free, which means the FIFO is empty.
- R3: A write phase starts only when the FIFO holds 1 DWORD (mode 00), or the smaller of 16 and the remaining count (mode 01). The phase writes exactly that many DWORDs.
- R4: Source and destination accesses never overlap. `a_req` and `b_req` are never high together, and every read beat of a phase completes before the first write beat.
- R5: In mode 01, when the count is not a multiple of 16, the final read phase and the final write phase each carry only the remaining DWORDs.
- R6: When `cfg_dir`=0 at start, port A is the source and port B the destination. When `cfg_dir`=1, the roles swap. The same phase rules apply in both directions.
- R7: Source and destination addresses each advance by 4 after every beat on their port. The destination receives the source DWORDs unchanged and in order, and nothing beyond the count is written.
- R8: A descriptor is fetched on the `d_` port as four reads at offsets 0, 4, 8 and 12 from the descriptor address. The words are, in order: source address, destination address, DWORD count and link address.
- R9: At the end of a descriptor, `cfg_link_halt`=0 makes the link field the next descriptor address and starts a new fetch. `cfg_link_halt`=1 produces a one-cycle `done` pulse, followed on the next cycle by `done_flag`=1. `done_flag` stays set until the next start.
- R10: A start with `cfg_mode[1]`=1 sets `err_flag` and produces no access on any port and no `done`. A later start with a valid mode clears `err_flag`.
- R11: A descriptor with a count of 0 moves no data and goes straight to the link decision.
- R12: After reset, `busy`, `done`, `done_flag`, `err_flag` and all request outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle start pulse, accepted in IDLE |
| start_ptr | input | 32 | Address of the first descriptor |
| cfg_mode | input | 2 | 00 single beat, 01 burst of 16, 1x reserved |
| cfg_dir | input | 1 | 0: A to B, 1: B to A |
| cfg_link_halt | input | 1 | Sampled at descriptor end; 0 follows the link |
| d_req | output | 1 | Descriptor read request |
| d_addr | output | 32 | Descriptor read address |
| d_rdata | input | 32 | Descriptor read data, valid with d_ack |
| d_ack | input | 1 | Descriptor beat complete |
| a_req | output | 1 | Port A request |
| a_we | output | 1 | Port A write enable |
| a_addr | output | 32 | Port A byte address |
| a_wdata | output | 32 | Port A write data |
| a_rdata | input | 32 | Port A read data, valid with a_ack |
| a_ack | input | 1 | Port A beat complete |
| b_req | output | 1 | Port B request |
| b_we | output | 1 | Port B write enable |
| b_addr | output | 32 | Port B byte address |
| b_wdata | output | 32 | Port B write data |
| b_rdata | input | 32 | Port B read data, valid with b_ack |
| b_ack | input | 1 | Port B beat complete |
| busy | output | 1 | High whenever the sequencer is not in IDLE |
| done | output | 1 | One-cycle pulse when the last descriptor completes |
| done_flag | output | 1 | Sticky completion flag, cleared by start |
| err_flag | output | 1 | Set by a start with a reserved mode |

## Verification
Most faults in the phase planner or FIFO bookkeeping change the pattern of beats at the ports. A wrong remaining count or FIFO level shows as a run of reads or writes of the wrong length, or as a missing shortened tail. The error is visible within one phase, at most 16 beats after it occurs, so the bench logs every completed beat with its port and its direction and compares the runs with the lengths computed from the count and the mode. A wrong address register shows as data landing at a shifted location, or as a neighbour word being overwritten. A wrong link decision shows as a fetch at an unexpected address on the descriptor port, or as extra or missing `done` pulses.

// File: rtl/dwd_chain_pkg.sv
package dwd_chain_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_FETCH,
        S_PLAN,
        S_RD,
        S_WR,
        S_LINK,
        S_FINISH,
        S_FAULT
    } seq_state_e;

    // word slots of a descriptor, in fetch order
    localparam logic [1:0] SLOT_SRC  = 2'd0;
    localparam logic [1:0] SLOT_DST  = 2'd1;
    localparam logic [1:0] SLOT_CNT  = 2'd2;
    localparam logic [1:0] SLOT_LINK = 2'd3;

endpackage

// File: rtl/dwd_stage_fifo.sv
module dwd_stage_fifo #(
    parameter int DW    = 32,
    parameter int DEPTH = 16,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [DW-1:0] head,
    output logic [LW-1:0] level
);

    logic [DW-1:0] store [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;

    generate
        if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
            assign wr_nxt = wr_ptr + PW'(1);
            assign rd_nxt = rd_ptr + PW'(1);
        end else begin : g_wrap
            assign wr_nxt = (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + PW'(1);
            assign rd_nxt = (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + PW'(1);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (push) store[wr_ptr] <= push_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (push) wr_ptr <= wr_nxt;
            if (pop)  rd_ptr <= rd_nxt;
            if (push && !pop)      level <= level + LW'(1);
            else if (pop && !push) level <= level - LW'(1);
        end
    end

    assign head = store[rd_ptr];

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (level != LW'(DEPTH)));  // R2
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (level != '0));  // R3

endmodule

// File: rtl/dwd_desc_regs.sv
module dwd_desc_regs
    import dwd_chain_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ptr_load,
    input  logic [AW-1:0] ptr_value,
    input  logic          link_follow,
    input  logic          word_we,
    input  logic [1:0]    word_idx,
    input  logic [DW-1:0] word_data,
    input  logic          rd_step,
    input  logic          wr_step,
    output logic [AW-1:0] chain_ptr,
    output logic [AW-1:0] src_addr,
    output logic [AW-1:0] dst_addr,
    output logic [DW-1:0] rd_left,
    output logic [DW-1:0] wr_left,
    output logic [AW-1:0] link_addr
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_ptr <= '0;
            src_addr  <= '0;
            dst_addr  <= '0;
            rd_left   <= '0;
            wr_left   <= '0;
            link_addr <= '0;
        end else begin
            if (ptr_load)         chain_ptr <= ptr_value;
            else if (link_follow) chain_ptr <= link_addr;

            if (word_we) begin
                unique case (word_idx)
                    SLOT_SRC:  src_addr  <= AW'(word_data);
                    SLOT_DST:  dst_addr  <= AW'(word_data);
                    SLOT_CNT: begin
                        rd_left <= word_data;
                        wr_left <= word_data;
                    end
                    SLOT_LINK: link_addr <= AW'(word_data);
                    default: ;
                endcase
            end else begin
                if (rd_step) begin
                    src_addr <= src_addr + AW'(4);
                    rd_left  <= rd_left - DW'(1);
                end
                if (wr_step) begin
                    dst_addr <= dst_addr + AW'(4);
                    wr_left  <= wr_left - DW'(1);
                end
            end
        end
    end

    AST_SRC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_step && !word_we) |=> (src_addr == $past(src_addr) + AW'(4)));  // R7
    AST_DST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_step && !word_we) |=> (dst_addr == $past(dst_addr) + AW'(4)));  // R7
    AST_COUNT_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        wr_left >= rd_left);  // R3
    AST_NO_STEP_PAST_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rd_step |-> (rd_left != '0));  // R7

endmodule

// File: rtl/dwd_phase_calc.sv
module dwd_phase_calc #(
    parameter int DW    = 32,
    parameter int DEPTH = 16,
    parameter int BURST = 16,
    localparam int LW   = $clog2(DEPTH + 1),
    localparam int PLW  = $clog2(BURST + 1)
) (
    input  logic           burst_mode,
    input  logic [DW-1:0]  rd_left,
    input  logic [DW-1:0]  wr_left,
    input  logic [LW-1:0]  level,
    output logic           rd_ok,
    output logic [PLW-1:0] rd_len,
    output logic           wr_ok,
    output logic [PLW-1:0] wr_len
);

    logic [DW-1:0] beat_n;
    logic [DW-1:0] free_n;
    logic [DW-1:0] level_n;
    logic [DW-1:0] rd_take;
    logic [DW-1:0] wr_take;

    always_comb begin
        beat_n  = burst_mode ? DW'(BURST) : DW'(1);
        level_n = DW'(level);
        free_n  = DW'(DEPTH) - level_n;
        rd_take = (rd_left < beat_n) ? rd_left : beat_n;
        wr_take = (wr_left < beat_n) ? wr_left : beat_n;
        rd_len  = PLW'(rd_take);
        wr_len  = PLW'(wr_take);
        rd_ok   = (rd_left != '0) && (free_n >= beat_n);
        wr_ok   = (wr_left != '0) && (level_n >= wr_take);
    end

endmodule

// File: rtl/dwd_chain_dma.sv
module dwd_chain_dma
    import dwd_chain_pkg::*;
#(
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int DEPTH = 16,
    parameter int BURST = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] start_ptr,
    input  logic [1:0]    cfg_mode,
    input  logic          cfg_dir,
    input  logic          cfg_link_halt,
    output logic          d_req,
    output logic [AW-1:0] d_addr,
    input  logic [DW-1:0] d_rdata,
    input  logic          d_ack,
    output logic          a_req,
    output logic          a_we,
    output logic [AW-1:0] a_addr,
    output logic [DW-1:0] a_wdata,
    input  logic [DW-1:0] a_rdata,
    input  logic          a_ack,
    output logic          b_req,
    output logic          b_we,
    output logic [AW-1:0] b_addr,
    output logic [DW-1:0] b_wdata,
    input  logic [DW-1:0] b_rdata,
    input  logic          b_ack,
    output logic          busy,
    output logic          done,
    output logic          done_flag,
    output logic          err_flag
);

    localparam int LW  = $clog2(DEPTH + 1);
    localparam int PLW = $clog2(BURST + 1);

    seq_state_e state_q, state_d;

    logic           burst_q, dir_q;
    logic [1:0]     fetch_idx;
    logic [PLW-1:0] ph_cnt;

    logic           src_req, dst_req;
    logic           src_ack, dst_ack;
    logic [DW-1:0]  src_rdata;
    logic           rd_step, wr_step, word_we;
    logic           ptr_load, link_follow, mode_bad;

    logic [AW-1:0]  chain_ptr, src_addr, dst_addr, link_addr;
    logic [DW-1:0]  rd_left, wr_left;
    logic [DW-1:0]  fifo_head;
    logic [LW-1:0]  fifo_level;
    logic           rd_ok, wr_ok;
    logic [PLW-1:0] rd_len, wr_len;

    // ---------------- submodules ----------------
    dwd_desc_regs #(.AW(AW), .DW(DW)) u_desc (
        .clk         (clk),
        .rst_n       (rst_n),
        .ptr_load    (ptr_load),
        .ptr_value   (start_ptr),
        .link_follow (link_follow),
        .word_we     (word_we),
        .word_idx    (fetch_idx),
        .word_data   (d_rdata),
        .rd_step     (rd_step),
        .wr_step     (wr_step),
        .chain_ptr   (chain_ptr),
        .src_addr    (src_addr),
        .dst_addr    (dst_addr),
        .rd_left     (rd_left),
        .wr_left     (wr_left),
        .link_addr   (link_addr)
    );

    dwd_stage_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (rd_step),
        .push_data (src_rdata),
        .pop       (wr_step),
        .head      (fifo_head),
        .level     (fifo_level)
    );

    dwd_phase_calc #(.DW(DW), .DEPTH(DEPTH), .BURST(BURST)) u_calc (
        .burst_mode (burst_q),
        .rd_left    (rd_left),
        .wr_left    (wr_left),
        .level      (fifo_level),
        .rd_ok      (rd_ok),
        .rd_len     (rd_len),
        .wr_ok      (wr_ok),
        .wr_len     (wr_len)
    );

    // ---------------- port steering ----------------
    assign mode_bad  = cfg_mode[1];
    assign src_ack   = dir_q ? b_ack : a_ack;
    assign dst_ack   = dir_q ? a_ack : b_ack;
    assign src_rdata = dir_q ? b_rdata : a_rdata;

    assign rd_step     = (state_q == S_RD) && src_ack;
    assign wr_step     = (state_q == S_WR) && dst_ack;
    assign word_we     = (state_q == S_FETCH) && d_ack;
    assign ptr_load    = (state_q == S_IDLE) && start && !mode_bad;
    assign link_follow = (state_q == S_LINK) && !cfg_link_halt;

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // ---------------- next state ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (start) state_d = mode_bad ? S_FAULT : S_FETCH;
            S_FETCH:  if (d_ack && fetch_idx == SLOT_LINK) state_d = S_PLAN;
            S_PLAN: begin
                if (wr_left == '0) state_d = S_LINK;
                else if (wr_ok)    state_d = S_WR;
                else if (rd_ok)    state_d = S_RD;
            end
            S_RD:     if (src_ack && ph_cnt == PLW'(1)) state_d = S_PLAN;
            S_WR:     if (dst_ack && ph_cnt == PLW'(1)) state_d = S_PLAN;
            S_LINK:   state_d = cfg_link_halt ? S_FINISH : S_FETCH;
            S_FINISH: state_d = S_IDLE;
            S_FAULT:  state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    // ---------------- outputs ----------------
    always_comb begin
        src_req = 1'b0;
        dst_req = 1'b0;
        d_req   = 1'b0;
        done    = 1'b0;
        busy    = (state_q != S_IDLE);
        unique case (state_q)
            S_FETCH:  d_req   = 1'b1;
            S_RD:     src_req = 1'b1;
            S_WR:     dst_req = 1'b1;
            S_FINISH: done    = 1'b1;
            default: ;
        endcase
        d_addr  = chain_ptr + {{(AW-4){1'b0}}, fetch_idx, 2'b00};
        a_req   = dir_q ? dst_req : src_req;
        a_we    = dir_q ? dst_req : 1'b0;
        a_addr  = dir_q ? dst_addr : src_addr;
        a_wdata = fifo_head;
        b_req   = dir_q ? src_req : dst_req;
        b_we    = dir_q ? 1'b0 : dst_req;
        b_addr  = dir_q ? src_addr : dst_addr;
        b_wdata = fifo_head;
    end

    // ---------------- sequencing registers ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            burst_q   <= 1'b0;
            dir_q     <= 1'b0;
            fetch_idx <= '0;
            ph_cnt    <= '0;
        end else begin
            unique case (state_q)
                S_IDLE: if (start) begin
                    burst_q   <= cfg_mode[0];
                    dir_q     <= cfg_dir;
                    fetch_idx <= '0;
                end
                S_FETCH: if (d_ack) fetch_idx <= fetch_idx + 2'd1;
                S_PLAN: begin
                    if (wr_ok)      ph_cnt <= wr_len;
                    else if (rd_ok) ph_cnt <= rd_len;
                end
                S_RD:   if (src_ack) ph_cnt <= ph_cnt - PLW'(1);
                S_WR:   if (dst_ack) ph_cnt <= ph_cnt - PLW'(1);
                S_LINK: fetch_idx <= '0;
                default: ;
            endcase
        end
    end

    // ---------------- flags ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_flag <= 1'b0;
            err_flag  <= 1'b0;
        end else begin
            if (state_q == S_IDLE && start) begin
                done_flag <= 1'b0;
                err_flag  <= mode_bad;
            end else if (state_q == S_FINISH) begin
                done_flag <= 1'b1;
            end
        end
    end

    // ---------------- assertions ----------------
    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        !(a_req && b_req));  // R4
    AST_RD_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_RD) |-> (int'(fifo_level) + int'(ph_cnt) <= DEPTH));  // R2
    AST_WR_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_WR) |-> (fifo_level >= LW'(ph_cnt)));  // R3
    AST_PHASE_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        int'(ph_cnt) <= BURST);  // R5
    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (done_flag && !done));  // R9
    AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |-> (!a_req && !b_req && !d_req && !done));  // R10

endmodule

// File: tb/test_dwd_chain_dma.sv
`timescale 1ns/1ps
module test_dwd_chain_dma;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] start_ptr = '0;
    logic [1:0]  cfg_mode = 2'b00;
    logic        cfg_dir = 1'b0;
    logic        cfg_link_halt = 1'b1;
    logic        d_req, a_req, a_we, b_req, b_we;
    logic [31:0] d_addr, a_addr, a_wdata, b_addr, b_wdata;
    logic [31:0] d_rdata, a_rdata, b_rdata;
    logic        d_ack, a_ack, b_ack;
    logic        busy, done, done_flag, err_flag;

    int n_tests = 0;
    int n_fail  = 0;

    logic [31:0] mem_a [256];
    logic [31:0] mem_b [256];
    logic [31:0] mem_d [64];

    logic log_port [256];
    logic log_we   [256];
    int   log_n = 0;
    logic [31:0] dlog [32];
    int   dlog_n = 0;
    int   done_pulses = 0;
    int   overlaps = 0;

    always #2 clk = ~clk;

    dwd_chain_dma i_dwd_chain_dma (
        .clk(clk), .rst_n(rst_n), .start(start), .start_ptr(start_ptr),
        .cfg_mode(cfg_mode), .cfg_dir(cfg_dir), .cfg_link_halt(cfg_link_halt),
        .d_req(d_req), .d_addr(d_addr), .d_rdata(d_rdata), .d_ack(d_ack),
        .a_req(a_req), .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata),
        .a_rdata(a_rdata), .a_ack(a_ack),
        .b_req(b_req), .b_we(b_we), .b_addr(b_addr), .b_wdata(b_wdata),
        .b_rdata(b_rdata), .b_ack(b_ack),
        .busy(busy), .done(done), .done_flag(done_flag), .err_flag(err_flag)
    );

    // memory models: ack one cycle after request, one beat per two cycles
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_ack <= 1'b0; b_ack <= 1'b0; d_ack <= 1'b0;
            a_rdata <= '0; b_rdata <= '0; d_rdata <= '0;
        end else begin
            a_ack <= a_req && !a_ack;
            b_ack <= b_req && !b_ack;
            d_ack <= d_req && !d_ack;
            if (a_req && !a_ack) begin
                a_rdata <= mem_a[a_addr[9:2]];
                if (a_we) mem_a[a_addr[9:2]] <= a_wdata;
            end
            if (b_req && !b_ack) begin
                b_rdata <= mem_b[b_addr[9:2]];
                if (b_we) mem_b[b_addr[9:2]] <= b_wdata;
            end
            if (d_req && !d_ack) d_rdata <= mem_d[d_addr[7:2]];
        end
    end

    // beat monitor
    always @(posedge clk) begin
        if (rst_n) begin
            if (a_ack && log_n < 256) begin log_port[log_n] = 1'b0; log_we[log_n] = a_we; log_n++; end
            if (b_ack && log_n < 256) begin log_port[log_n] = 1'b1; log_we[log_n] = b_we; log_n++; end
            if (d_ack && dlog_n < 32) begin dlog[dlog_n] = d_addr; dlog_n++; end
            if (done) done_pulses++;
            if (a_req && b_req) overlaps++;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=0x%08h expected=0x%08h", req, what, act, exp);
        end
    endtask

    task automatic fill_mems();
        for (int i = 0; i < 256; i++) begin
            mem_a[i] = 32'hA000_0000 | i;
            mem_b[i] = 32'hB000_0000 | i;
        end
    endtask

    task automatic put_desc(input int base, input int s, input int d, input int c, input int l);
        mem_d[(base >> 2) + 0] = s;
        mem_d[(base >> 2) + 1] = d;
        mem_d[(base >> 2) + 2] = c;
        mem_d[(base >> 2) + 3] = l;
    endtask

    task automatic clear_logs();
        log_n = 0; dlog_n = 0; done_pulses = 0; overlaps = 0;
    endtask

    task automatic kick(input int ptr);
        @(negedge clk);
        start_ptr = ptr;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(input int limit);
        for (int i = 0; i < limit; i++) begin
            if (done_flag) break;
            @(negedge clk);
        end
        repeat (2) @(negedge clk);
    endtask

    // compare beat log against runs computed from count and mode
    task automatic check_runs(input int cnt, input int blen, input bit src_b, input string req);
        int pos = 0;
        int rem = cnt;
        int bad = -1;
        while (rem > 0) begin
            int len = (rem < blen) ? rem : blen;
            for (int k = 0; k < len; k++) begin
                if (bad < 0 && (pos >= log_n || log_port[pos] != src_b || log_we[pos] != 1'b0)) bad = pos;
                pos++;
            end
            for (int k = 0; k < len; k++) begin
                if (bad < 0 && (pos >= log_n || log_port[pos] != !src_b || log_we[pos] != 1'b1)) bad = pos;
                pos++;
            end
            rem -= len;
        end
        if (bad < 0 && pos != log_n) bad = pos;
        check(bad < 0, req, "beat run pattern (first bad index)", bad, 32'hFFFF_FFFF);
        check(log_n == 2 * cnt, req, "beat total", log_n, 2 * cnt);
    endtask

    task automatic check_data(input bit dst_is_a, input int s, input int d, input int cnt, input string req);
        int bad = 0;
        logic [31:0] exp_word, got;
        for (int i = 0; i < cnt; i++) begin
            exp_word = dst_is_a ? (32'hB000_0000 | ((s >> 2) + i)) : (32'hA000_0000 | ((s >> 2) + i));
            got = dst_is_a ? mem_a[(d >> 2) + i] : mem_b[(d >> 2) + i];
            if (got !== exp_word) bad++;
        end
        check(bad == 0, req, "copied words mismatching", bad, 0);
        exp_word = dst_is_a ? (32'hA000_0000 | ((d >> 2) + cnt)) : (32'hB000_0000 | ((d >> 2) + cnt));
        got = dst_is_a ? mem_a[(d >> 2) + cnt] : mem_b[(d >> 2) + cnt];
        check(got === exp_word, req, "word after end untouched", got, exp_word);
    endtask

    task automatic test_reset();
        check(busy == 0 && done == 0, "R12", "busy/done after reset", {busy, done}, 0);
        check(done_flag == 0 && err_flag == 0, "R12", "flags after reset", {done_flag, err_flag}, 0);
        check(!a_req && !b_req && !d_req, "R12", "requests after reset", {a_req, b_req, d_req}, 0);
    endtask

    task automatic test_single();
        fill_mems(); clear_logs();
        put_desc(32'h00, 32'h010, 32'h020, 3, 32'h0);
        cfg_mode = 2'b00; cfg_dir = 1'b0; cfg_link_halt = 1'b1;
        kick(32'h00);
        wait_done(400);
        check_runs(3, 1, 1'b0, "R1");
        check_data(1'b0, 32'h010, 32'h020, 3, "R7");
        check(dlog_n == 4, "R8", "descriptor reads", dlog_n, 4);
        for (int i = 0; i < 4; i++)
            check(dlog[i] == 32'(4 * i), "R8", "descriptor read address", dlog[i], 4 * i);
        check(done_flag == 1 && done_pulses == 1, "R9", "done flag / pulse count", done_pulses, 1);
        check(busy == 0, "R9", "idle after finish", busy, 0);
    endtask

    task automatic test_burst_tail();
        fill_mems(); clear_logs();
        put_desc(32'h00, 32'h000, 32'h100, 37, 32'h0);
        cfg_mode = 2'b01; cfg_dir = 1'b0; cfg_link_halt = 1'b1;
        kick(32'h00);
        wait_done(2000);
        check_runs(37, 16, 1'b0, "R5");
        check_data(1'b0, 32'h000, 32'h100, 37, "R7");
        check(overlaps == 0, "R4", "cycles with both ports requesting", overlaps, 0);
    endtask

    task automatic test_reverse();
        fill_mems(); clear_logs();
        put_desc(32'h00, 32'h040, 32'h300, 16, 32'h0);
        cfg_mode = 2'b01; cfg_dir = 1'b1; cfg_link_halt = 1'b1;
        kick(32'h00);
        wait_done(2000);
        check_runs(16, 16, 1'b1, "R6");
        check_data(1'b1, 32'h040, 32'h300, 16, "R6");
        check(done_flag == 1, "R6", "done after reverse copy", done_flag, 1);
    endtask

    task automatic test_chain();
        fill_mems(); clear_logs();
        put_desc(32'h40, 32'h000, 32'h100, 5, 32'h80);
        put_desc(32'h80, 32'h080, 32'h200, 2, 32'h00);
        cfg_mode = 2'b01; cfg_dir = 1'b0; cfg_link_halt = 1'b0;
        fork
            begin
                while (!(d_req && d_addr == 32'h80)) @(negedge clk);
                cfg_link_halt = 1'b1;
            end
        join_none
        kick(32'h40);
        wait_done(2000);
        check(dlog_n == 8, "R9", "descriptor reads across chain", dlog_n, 8);
        for (int i = 0; i < 4; i++) begin
            check(dlog[i] == 32'(32'h40 + 4 * i), "R8", "first descriptor address", dlog[i], 32'h40 + 4 * i);
            check(dlog[4 + i] == 32'(32'h80 + 4 * i), "R9", "linked descriptor address", dlog[4 + i], 32'h80 + 4 * i);
        end
        check_data(1'b0, 32'h000, 32'h100, 5, "R9");
        check_data(1'b0, 32'h080, 32'h200, 2, "R9");
        check(done_pulses == 1, "R9", "single done pulse for chain", done_pulses, 1);
    endtask

    task automatic test_reserved();
        clear_logs();
        cfg_mode = 2'b10; cfg_dir = 1'b0; cfg_link_halt = 1'b1;
        kick(32'h00);
        repeat (20) @(negedge clk);
        check(err_flag == 1, "R10", "error flag on reserved mode", err_flag, 1);
        check(log_n == 0 && dlog_n == 0, "R10", "no bus beats", log_n + dlog_n, 0);
        check(done_flag == 0 && done_pulses == 0, "R10", "no completion", done_pulses, 0);
        check(busy == 0, "R10", "idle after fault", busy, 0);
    endtask

    task automatic test_zero();
        fill_mems(); clear_logs();
        put_desc(32'h00, 32'h000, 32'h100, 0, 32'h0);
        cfg_mode = 2'b00; cfg_dir = 1'b0; cfg_link_halt = 1'b1;
        kick(32'h00);
        wait_done(200);
        check(err_flag == 0, "R10", "error cleared by valid start", err_flag, 0);
        check(log_n == 0, "R11", "no data beats for zero count", log_n, 0);
        check(dlog_n == 4, "R11", "descriptor still fetched", dlog_n, 4);
        check(done_flag == 1 && done_pulses == 1, "R11", "completion for zero count", done_pulses, 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 64; i++) mem_d[i] = '0;
        fill_mems();
        repeat (3) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        test_single();
        test_burst_tail();
        test_reverse();
        test_chain();
        test_reserved();
        test_zero();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule